// File: doc/BRIEF.md
# Triple-Input Line Diagnosis Selector

This block sits between the receive comparators of a two-wire bus and the bit decoder. It looks at three already synchronised receive signals: a differential one and two single-ended ones, one per wire. It works out whether either wire is faulty and routes one of the three signals to the decoder as `rx_data`. A 2-bit mode input either forces one of the three inputs or lets a small diagnosis state machine pick the input. The same block drives the transmit pin and can invert its polarity. It can also invert all receive inputs.

Two kinds of diagnosis feed the state machine. The synchronous check counts edges on the routed input during each period of a diagnosis clock. That clock is divided down from the timeslot tick by 2^(code+6). A period with too few edges means the line is dead. The transmit check waits two timeslot ticks after each dominant-to-recessive transmit transition and then compares each wire input with the transmitted level. The state machine has four states:
- NORMAL
- RX1_BAD, which reads rx2
- RX2_BAD, which reads rx1
- MAJOR

Its transitions are named FAULT_ONE (NORMAL to a single-wire state), FAULT_BOTH (any state to MAJOR), RESTORE_AUTO (two consecutive clean diagnosis edges in automatic mode) and RESTORE_IDLE (return-to-idle pulse in a forced mode). General reset also returns the machine to NORMAL.

Top module: `line_diag_select`

## Requirements
- R1: With `mode` 00, 01 or 10, the routed input is forced to differential, rx2 or rx1 respectively. `rx_src` reads the same code as `mode` (00 differential, 01 rx2, 10 rx1), and `rx_data` follows that input.
- R2: With `mode` 11, the routing follows `diag_state`. `diag_state` is encoded 00 NORMAL, 01 RX1_BAD, 10 RX2_BAD and 11 MAJOR. NORMAL and MAJOR route differential (`rx_src` 00), RX1_BAD routes rx2 (01) and RX2_BAD routes rx1 (10).
- R3: At each diagnosis edge, if the routed input showed fewer than 4 edges during the period just ended, the state becomes MAJOR (11). With 4 or more edges, no fault is recorded.
- R4: `diag_edge` is a one-cycle pulse every 2^(`sdc_code`+6) timeslot ticks. Codes above 10 behave as 10, which gives 65536.
- R5: Two timeslot ticks after `tx_data` rises (dominant 0 to recessive 1), each wire input is compared with `tx_data`. An rx1 mismatch alone moves NORMAL to RX1_BAD (01), and an rx2 mismatch alone moves NORMAL to RX2_BAD (10). A mismatch on both wires, or a mismatch on the second wire while the other is already faulty, gives MAJOR.
- R6: In mode 11, a faulty state returns to NORMAL only after two consecutive diagnosis edges that each end a period with at least 4 edges and no transmit mismatch. One such edge is not enough.
- R7: In a forced mode, clean diagnosis periods never restore NORMAL. A one-cycle `ri_pulse` does.
- R8: `txd_out` equals `tx_data` XOR `inv_tx`. Each receive input is XORed with `inv_rx` before any use. With inversion off, an idle raw 1 is recessive.
- R9: After reset, `diag_state` is NORMAL and `diag_edge` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous general reset, active low |
| ts_tick | input | 1 | Timeslot clock enable |
| mode | input | 2 | Selection mode (00 diff, 01 rx2, 10 rx1, 11 automatic) |
| sdc_code | input | 4 | Diagnosis clock divider code |
| inv_tx | input | 1 | Invert transmit output |
| inv_rx | input | 1 | Invert all receive inputs |
| tx_data | input | 1 | Logical transmit level, 1 recessive |
| rx1_raw | input | 1 | Single-ended receive, first wire |
| rx2_raw | input | 1 | Single-ended receive, second wire |
| rxd_raw | input | 1 | Differential receive |
| ri_pulse | input | 1 | Return-to-idle pulse at end of frame |
| txd_out | output | 1 | Transmit pin level |
| rx_data | output | 1 | Routed logical receive data |
| rx_src | output | 2 | Routed input code |
| diag_state | output | 2 | Diagnosis state |
| diag_edge | output | 1 | Diagnosis clock rising-edge pulse |

## Verification
The bench drives the following patterns:
- Quiet lines, which separate a dead bus from a live one.
- Bursts of 3 and of 4 simultaneous edges on all three inputs, which pin the synchronous threshold.
- Transmit pulses with rx1 stuck, rx2 stuck, or both stuck, which tell single-wire faults from escalation and from a double fault.
- Long clean runs under a forced mode, followed by a return-to-idle pulse, which show that only the pulse restores there.
- A seeded random mix of modes, raw levels and polarity bits, with routing, data and transmit level checked against bench functions that use the reported state.

Pulse spacing is measured at three divider codes, including a clamped one.

// File: rtl/lds_pkg.sv
package lds_pkg;

    typedef enum logic [1:0] {
        DG_NORMAL  = 2'b00,
        DG_RX1_BAD = 2'b01,
        DG_RX2_BAD = 2'b10,
        DG_MAJOR   = 2'b11
    } diag_st_t;

    typedef enum logic [1:0] {
        SRC_DIFF = 2'b00,
        SRC_RX2  = 2'b01,
        SRC_RX1  = 2'b10
    } src_t;

    localparam logic [1:0] MODE_AUTO = 2'b11;

    // line vector index order used throughout
    localparam int LINE_DIFF = 0;
    localparam int LINE_RX2  = 1;
    localparam int LINE_RX1  = 2;
    localparam int N_LINES   = 3;

endpackage

// File: rtl/lds_diag_div.sv
module lds_diag_div #(
    parameter int CODE_MAX  = 10,
    parameter int MIN_SHIFT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] code,
    output logic       edge_o
);
    localparam int DIV_W = CODE_MAX + MIN_SHIFT + 1;

    logic [3:0]       code_c;
    logic [4:0]       shift;
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] cnt;

    assign code_c = (code > 4'(CODE_MAX)) ? 4'(CODE_MAX) : code;
    assign shift  = {1'b0, code_c} + 5'(MIN_SHIFT);
    assign limit  = (DIV_W'(1) << shift) - DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            edge_o <= 1'b0;
        end else begin
            edge_o <= 1'b0;
            if (tick) begin
                if (cnt >= limit) begin
                    cnt    <= '0;
                    edge_o <= 1'b1;
                end else begin
                    cnt <= cnt + DIV_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/lds_tx_check.sv
module lds_tx_check #(
    parameter int TX_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_l,
    input  logic rx1_l,
    input  logic rx2_l,
    output logic chk_o,
    output logic bad1_o,
    output logic bad2_o
);
    localparam int DW = $clog2(TX_DLY + 1);

    logic          tx_prev;
    logic [DW-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_prev <= 1'b1;
            pend    <= '0;
            chk_o   <= 1'b0;
            bad1_o  <= 1'b0;
            bad2_o  <= 1'b0;
        end else begin
            tx_prev <= tx_l;
            chk_o   <= 1'b0;
            bad1_o  <= 1'b0;
            bad2_o  <= 1'b0;
            if (tx_l && !tx_prev) begin
                pend <= DW'(TX_DLY);
            end else if (tick && pend != '0) begin
                pend <= pend - DW'(1);
                if (pend == DW'(1)) begin
                    chk_o  <= 1'b1;
                    bad1_o <= (rx1_l != tx_l);
                    bad2_o <= (rx2_l != tx_l);
                end
            end
        end
    end

endmodule

// File: rtl/lds_edge_count.sv
module lds_edge_count #(
    parameter int EDGE_MIN = 4,
    parameter int N_LINES  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] sel_mask,
    input  logic               clr,
    output logic               enough_o
);
    localparam int CW = $clog2(EDGE_MIN + 1);

    logic [N_LINES-1:0] prev;
    logic [CW-1:0]      cnt;
    logic               hit;

    assign hit      = |((lines ^ prev) & sel_mask);
    assign enough_o = (cnt >= CW'(EDGE_MIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
            cnt  <= '0;
        end else begin
            prev <= lines;
            if (clr) begin
                cnt <= hit ? CW'(1) : '0;
            end else if (hit && cnt < CW'(EDGE_MIN)) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/lds_diag_fsm.sv
module lds_diag_fsm
    import lds_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     auto_en,
    input  logic     diag_edge,
    input  logic     enough,
    input  logic     chk,
    input  logic     bad1,
    input  logic     bad2,
    input  logic     ri,
    output diag_st_t state
);
    diag_st_t state_n;
    logic     good_run;
    logic     per_fail;
    logic     tx_f1, tx_f2, sync_f, clean, restore;

    assign tx_f1   = chk & bad1;
    assign tx_f2   = chk & bad2;
    assign sync_f  = diag_edge & ~enough;
    assign clean   = diag_edge & enough & ~per_fail & ~tx_f1 & ~tx_f2;
    assign restore = (auto_en & clean & good_run) | (~auto_en & ri);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DG_NORMAL;
        end else begin
            state <= state_n;
        end
    end

    // period bookkeeping for the recovery rule
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_run <= 1'b0;
            per_fail <= 1'b0;
        end else begin
            if (diag_edge) begin
                good_run <= clean;
                per_fail <= 1'b0;
            end else if (tx_f1 || tx_f2) begin
                per_fail <= 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            DG_NORMAL: begin
                if (sync_f || (tx_f1 && tx_f2)) state_n = DG_MAJOR;    // FAULT_BOTH
                else if (tx_f1)                 state_n = DG_RX1_BAD;  // FAULT_ONE
                else if (tx_f2)                 state_n = DG_RX2_BAD;  // FAULT_ONE
            end
            DG_RX1_BAD: begin
                if (sync_f || tx_f2)            state_n = DG_MAJOR;
                else if (!tx_f1 && restore)     state_n = DG_NORMAL;
            end
            DG_RX2_BAD: begin
                if (sync_f || tx_f1)            state_n = DG_MAJOR;
                else if (!tx_f2 && restore)     state_n = DG_NORMAL;
            end
            DG_MAJOR: begin
                if (!sync_f && !tx_f1 && !tx_f2 && restore) state_n = DG_NORMAL;
            end
        endcase
    end

endmodule

// File: rtl/line_diag_select.sv
module line_diag_select
    import lds_pkg::*;
#(
    parameter int CODE_MAX  = 10,
    parameter int MIN_SHIFT = 6,
    parameter int EDGE_MIN  = 4,
    parameter int TX_DLY    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ts_tick,
    input  logic [1:0] mode,
    input  logic [3:0] sdc_code,
    input  logic       inv_tx,
    input  logic       inv_rx,
    input  logic       tx_data,
    input  logic       rx1_raw,
    input  logic       rx2_raw,
    input  logic       rxd_raw,
    input  logic       ri_pulse,
    output logic       txd_out,
    output logic       rx_data,
    output logic [1:0] rx_src,
    output logic [1:0] diag_state,
    output logic       diag_edge
);
    logic [N_LINES-1:0] raw_v;
    logic [N_LINES-1:0] lines;
    logic [N_LINES-1:0] sel_mask;
    src_t               src;
    diag_st_t           state;
    logic               auto_en;
    logic               edge_ok;
    logic               tx_chk, tx_bad1, tx_bad2;

    assign raw_v[LINE_DIFF] = rxd_raw;
    assign raw_v[LINE_RX2]  = rx2_raw;
    assign raw_v[LINE_RX1]  = rx1_raw;

    for (genvar g = 0; g < N_LINES; g++) begin : g_pol
        assign lines[g] = raw_v[g] ^ inv_rx;
    end

    assign auto_en = (mode == MODE_AUTO);
    assign txd_out = tx_data ^ inv_tx;

    lds_diag_div #(.CODE_MAX(CODE_MAX), .MIN_SHIFT(MIN_SHIFT)) div_i (
        .clk(clk), .rst_n(rst_n), .tick(ts_tick), .code(sdc_code), .edge_o(diag_edge)
    );

    lds_tx_check #(.TX_DLY(TX_DLY)) txc_i (
        .clk(clk), .rst_n(rst_n), .tick(ts_tick), .tx_l(tx_data),
        .rx1_l(lines[LINE_RX1]), .rx2_l(lines[LINE_RX2]),
        .chk_o(tx_chk), .bad1_o(tx_bad1), .bad2_o(tx_bad2)
    );

    lds_edge_count #(.EDGE_MIN(EDGE_MIN), .N_LINES(N_LINES)) ecnt_i (
        .clk(clk), .rst_n(rst_n), .lines(lines), .sel_mask(sel_mask),
        .clr(diag_edge), .enough_o(edge_ok)
    );

    lds_diag_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .diag_edge(diag_edge),
        .enough(edge_ok), .chk(tx_chk), .bad1(tx_bad1), .bad2(tx_bad2),
        .ri(ri_pulse), .state(state)
    );

    // output process: routing from mode and state
    always_comb begin
        if (!auto_en) begin
            src = src_t'(mode);
        end else begin
            unique case (state)
                DG_NORMAL:  src = SRC_DIFF;
                DG_RX1_BAD: src = SRC_RX2;
                DG_RX2_BAD: src = SRC_RX1;
                DG_MAJOR:   src = SRC_DIFF;
            endcase
        end
        unique case (src)
            SRC_RX2: sel_mask = 3'b1 << LINE_RX2;
            SRC_RX1: sel_mask = 3'b1 << LINE_RX1;
            default: sel_mask = 3'b1 << LINE_DIFF;
        endcase
    end

    assign rx_data    = |(lines & sel_mask);
    assign rx_src     = src;
    assign diag_state = state;

endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
    parameter int EDGE_MIN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [1:0] rx_src,
    input logic [1:0] diag_state,
    input logic       diag_edge,
    input logic       ri_pulse,
    input logic       tx_chk,
    input logic       edge_ok
);
    AST_FORCED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11) |-> (rx_src == mode)); // R1

    AST_AUTO_ROUTE_RX2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && diag_state == 2'b01) |-> (rx_src == 2'b01)); // R2

    AST_SYNC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_edge && !edge_ok) |=> (diag_state == 2'b11)); // R3

    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        diag_edge |=> !diag_edge); // R4

    AST_MAJOR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_state != 2'b11 && !diag_edge && !tx_chk) |=> (diag_state != 2'b11)); // R5

    AST_RESTORE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_state != 2'b00 && !diag_edge && !ri_pulse) |=> (diag_state != 2'b00)); // R6

endmodule

bind line_diag_select lds_checker #(.EDGE_MIN(EDGE_MIN)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_src(rx_src),
    .diag_state(diag_state), .diag_edge(diag_edge), .ri_pulse(ri_pulse),
    .tx_chk(tx_chk), .edge_ok(edge_ok)
);

// File: tb/line_diag_select_tb_top.sv
module line_diag_select_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ts_tick;
    logic [1:0] mode;
    logic [3:0] sdc_code;
    logic       inv_tx, inv_rx, tx_data;
    logic       rx1_raw, rx2_raw, rxd_raw, ri_pulse;
    logic       txd_out, rx_data, diag_edge;
    logic [1:0] rx_src, diag_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    line_diag_select dut_i (
        .clk(clk), .rst_n(rst_n), .ts_tick(ts_tick), .mode(mode), .sdc_code(sdc_code),
        .inv_tx(inv_tx), .inv_rx(inv_rx), .tx_data(tx_data),
        .rx1_raw(rx1_raw), .rx2_raw(rx2_raw), .rxd_raw(rxd_raw), .ri_pulse(ri_pulse),
        .txd_out(txd_out), .rx_data(rx_data), .rx_src(rx_src),
        .diag_state(diag_state), .diag_edge(diag_edge)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_src(logic [1:0] m, logic [1:0] st);
        if (m != 2'b11) return m;
        case (st)
            2'b01:   return 2'b01;
            2'b10:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic exp_rx(logic [1:0] s, logic r1, logic r2, logic rd, logic inv);
        case (s)
            2'b01:   return r2 ^ inv;
            2'b10:   return r1 ^ inv;
            default: return rd ^ inv;
        endcase
    endfunction

    task automatic wait_edge();
        do @(negedge clk); while (diag_edge !== 1'b1);
        @(negedge clk);
    endtask

    task automatic toggle_all(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx1_raw = ~rx1_raw; rx2_raw = ~rx2_raw; rxd_raw = ~rxd_raw;
            @(negedge clk);
        end
    endtask

    task automatic recover();
        for (int i = 0; i < 3; i++) begin
            toggle_all(6);
            wait_edge();
        end
    endtask

    // dominant transmit pulse; a wire that is not ok stays dominant after tx goes recessive
    task automatic tx_pulse(bit r1_ok, bit r2_ok);
        @(negedge clk);
        tx_data = 1'b0; rx1_raw = 1'b0; rx2_raw = 1'b0;
        repeat (3) @(negedge clk);
        tx_data = 1'b1; rx1_raw = r1_ok; rx2_raw = r2_ok;
        repeat (8) @(negedge clk);
        rx1_raw = 1'b1; rx2_raw = 1'b1;
    endtask

    task automatic measure(int exp_cycles, string tag);
        int n;
        wait_edge();
        n = 1;
        do begin @(negedge clk); n++; end while (diag_edge !== 1'b1);
        check(tag, n, exp_cycles);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_ED01));
        rst_n = 1'b0; ts_tick = 1'b1; mode = 2'b11; sdc_code = 4'd0;
        inv_tx = 1'b0; inv_rx = 1'b0; tx_data = 1'b1;
        rx1_raw = 1'b1; rx2_raw = 1'b1; rxd_raw = 1'b1; ri_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R9 state after reset", diag_state, 2'b00);
        check("R9 diag_edge after reset", diag_edge, 1'b0);
        check("R2 auto NORMAL routes diff", rx_src, 2'b00);
        check("R8 idle txd_out", txd_out, 1'b1);

        // quiet bus -> major
        wait_edge();
        check("R3 quiet period gives MAJOR", diag_state, 2'b11);
        check("R2 MAJOR routes diff", rx_src, 2'b00);

        // one clean period is not enough, two are
        toggle_all(6); wait_edge();
        check("R6 one clean edge keeps MAJOR", diag_state, 2'b11);
        toggle_all(6); wait_edge();
        check("R6 two clean edges restore NORMAL", diag_state, 2'b00);

        // threshold 4 / 3 edges
        toggle_all(4); wait_edge();
        check("R3 four edges keep NORMAL", diag_state, 2'b00);
        toggle_all(3); wait_edge();
        check("R3 three edges give MAJOR", diag_state, 2'b11);

        // transmit diagnosis: single wire faults, escalation
        recover();
        check("R6 recovered before tx test", diag_state, 2'b00);
        tx_pulse(1'b1, 1'b0);
        check("R5 rx2 mismatch gives RX2_BAD", diag_state, 2'b10);
        check("R2 RX2_BAD routes rx1", rx_src, 2'b10);
        @(negedge clk); rx1_raw = 1'b0; #1;
        check("R2 rx_data follows rx1 low", rx_data, 1'b0);
        @(negedge clk); rx1_raw = 1'b1; #1;
        check("R2 rx_data follows rx1 high", rx_data, 1'b1);
        tx_pulse(1'b0, 1'b1);
        check("R5 second wire fault escalates to MAJOR", diag_state, 2'b11);

        recover();
        check("R6 recovered from MAJOR", diag_state, 2'b00);
        tx_pulse(1'b0, 1'b1);
        check("R5 rx1 mismatch gives RX1_BAD", diag_state, 2'b01);
        check("R2 RX1_BAD routes rx2", rx_src, 2'b01);

        recover();
        check("R6 recovered from RX1_BAD", diag_state, 2'b00);
        tx_pulse(1'b0, 1'b0);
        check("R5 both mismatch gives MAJOR", diag_state, 2'b11);

        // forced modes
        @(negedge clk); mode = 2'b01; #1;
        check("R1 mode 01 routes rx2", rx_src, 2'b01);
        rx2_raw = 1'b0; #1;
        check("R1 rx_data follows rx2", rx_data, 1'b0);
        rx2_raw = 1'b1;
        recover();
        check("R7 clean periods do not restore in forced mode", diag_state, 2'b11);
        @(negedge clk); ri_pulse = 1'b1;
        @(negedge clk); ri_pulse = 1'b0;
        check("R7 ri_pulse restores NORMAL", diag_state, 2'b00);
        mode = 2'b10; #1;
        check("R1 mode 10 routes rx1", rx_src, 2'b10);
        mode = 2'b00; #1;
        check("R1 mode 00 routes diff", rx_src, 2'b00);

        // polarity
        @(negedge clk); inv_tx = 1'b1; #1;
        check("R8 inverted txd_out", txd_out, 1'b0);
        inv_rx = 1'b1; rxd_raw = 1'b0; #1;
        check("R8 inverted rx_data", rx_data, 1'b1);
        inv_tx = 1'b0; inv_rx = 1'b0; rxd_raw = 1'b1;

        // divider
        mode = 2'b11;
        sdc_code = 4'd1; measure(128, "R4 code 1 period");
        sdc_code = 4'd2; measure(256, "R4 code 2 period");
        sdc_code = 4'd15; measure(65536, "R4 clamped code period");
        sdc_code = 4'd0; wait_edge();

        // random routing and polarity
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            mode    = 2'($urandom_range(0, 3));
            rx1_raw = 1'($urandom); rx2_raw = 1'($urandom); rxd_raw = 1'($urandom);
            inv_rx  = 1'($urandom); inv_tx = 1'($urandom); tx_data = 1'($urandom);
            #1;
            check("R1/R2 random route", rx_src, exp_src(mode, diag_state));
            check("R8 random rx_data", rx_data,
                  exp_rx(exp_src(mode, diag_state), rx1_raw, rx2_raw, rxd_raw, inv_rx));
            check("R8 random txd_out", txd_out, tx_data ^ inv_tx);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule